// File: doc/BRIEF.md
# Interrupt aggregation ring writer

The block takes indirect interrupt requests from queue sources and turns each into one entry of a circular aggregation ring held in host memory. Every request names a ring, a queue id, a direction flag and a status descriptor. The ring index picks one entry of an internal context table. That entry holds the ring's base address, its size in entries, the current producer index, the current phase (color) bit, the message vector and the owning function.

For each accepted request, the block forms the entry address from the base and the producer index, and issues a memory write whose payload is tagged with the ring's color. It then advances the producer index. When the index wraps from the last slot to the first, the color inverts, so a consumer can tell fresh entries from stale ones. The message request with the ring's vector is raised only after the memory write completion returns. A programming port loads contexts. Loading a context resets its producer index to zero and sets its starting color, which software normally sets to 1 over ring memory cleared to 0.

Only one request is in flight at a time. Software has to size every ring larger than three times the number of queues mapped to it, because each source may have up to three interrupts outstanding.

Top module: `irq_ring_writer`

## Requirements
- R1: While reset is held, and after it is released, `req_ready_o` is 1 and both `mem_wr_valid_o` and `msix_valid_o` are 0.
- R2: Each accepted request produces exactly one memory write. Its address is the selected ring's base plus producer index times ENTRY_BYTES (8 by default).
- R3: The write payload has the color in bit 0 and the direction in bit 1 (1 = C2H, 0 = H2C). The queue id is in bits [12:2] and the status descriptor in bits [44:13].
- R4: The producer index of a ring advances by one per accepted request and returns to 0 after slot size-1.
- R5: A ring's color inverts each time its producer index wraps, and the inverted value is carried by later entries. Programming a context loads its color and sets its producer index to 0.
- R6: The message request is raised only after `mem_cpl_i` has returned for the pending write. It carries the vector and function of the ring that took the entry, and it is never valid together with a memory write.
- R7: `req_ready_o` is 0 from the acceptance of a request until its message handshake completes.
- R8: In a cycle where `cfg_we_i` is 1, no request is accepted. A request waiting in that cycle is served afterwards with the newly programmed context.
- R9: Entries written to one ring leave the producer index and color of every other ring unchanged.
- R10: While `mem_wr_valid_o` or `msix_valid_o` is 1 and the matching ready is 0, the valid stays high and the address, data, vector and function outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Interrupt request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_ring_i | input | RING_W | Aggregation ring index |
| req_qid_i | input | QID_W | Queue id of the source |
| req_c2h_i | input | 1 | Direction: 1 = C2H, 0 = H2C |
| req_stat_i | input | STAT_W | Status descriptor of the source |
| cfg_we_i | input | 1 | Context write strobe |
| cfg_ring_i | input | RING_W | Context entry to program |
| cfg_base_i | input | ADDR_W | Ring base address |
| cfg_size_i | input | IDX_W | Ring size in entries |
| cfg_color_i | input | 1 | Starting color |
| cfg_vec_i | input | VEC_W | Message vector |
| cfg_func_i | input | FUNC_W | Owning function |
| mem_wr_valid_o | output | 1 | Ring entry write request |
| mem_wr_ready_i | input | 1 | Memory side accepts the write |
| mem_wr_addr_o | output | ADDR_W | Entry byte address |
| mem_wr_data_o | output | ENTRY_W | Entry payload |
| mem_cpl_i | input | 1 | Write completion pulse |
| msix_valid_o | output | 1 | Message request valid |
| msix_ready_i | input | 1 | Message request accepted |
| msix_vec_o | output | VEC_W | Message vector |
| msix_func_o | output | FUNC_W | Owning function |

## Verification
A scoreboard keeps its own copy of each context. The bench drives long runs into small rings, so the producer index wraps more than once. Colour and address errors at the wrap boundary therefore show up, in particular an index that goes one slot too far or too few. Requests to three rings are interleaved, which separates correct per-ring state from state that leaks between rings, and the last ring index exercises the top of the table. The memory and message sides stall in irregular patterns and the completion arrives with varying delay, which exposes a message raised early and outputs that change during a stall. A programming write that coincides with a pending request, and a later reprogramming with color 0, check the precedence of the programming port and the reload of the index and color.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_WAIT_CPL,
    ST_MSIX
  } agg_state_e;
endpackage

// File: rtl/irq_ctx_table.sv
module irq_ctx_table #(
  parameter int NUM_RINGS = 256,
  parameter int RING_W    = 8,
  parameter int ADDR_W    = 64,
  parameter int IDX_W     = 12,
  parameter int VEC_W     = 11,
  parameter int FUNC_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [RING_W-1:0] cfg_ring_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [IDX_W-1:0]  cfg_size_i,
  input  logic              cfg_color_i,
  input  logic [VEC_W-1:0]  cfg_vec_i,
  input  logic [FUNC_W-1:0] cfg_func_i,
  input  logic              upd_we_i,
  input  logic [RING_W-1:0] upd_ring_i,
  input  logic [IDX_W-1:0]  upd_pidx_i,
  input  logic              upd_color_i,
  input  logic [RING_W-1:0] rd_ring_i,
  output logic [ADDR_W-1:0] rd_base_o,
  output logic [IDX_W-1:0]  rd_size_o,
  output logic [IDX_W-1:0]  rd_pidx_o,
  output logic              rd_color_o,
  output logic [VEC_W-1:0]  rd_vec_o,
  output logic [FUNC_W-1:0] rd_func_o
);
  logic [ADDR_W-1:0] base_q  [NUM_RINGS];
  logic [IDX_W-1:0]  size_q  [NUM_RINGS];
  logic [IDX_W-1:0]  pidx_q  [NUM_RINGS];
  logic              color_q [NUM_RINGS];
  logic [VEC_W-1:0]  vec_q   [NUM_RINGS];
  logic [FUNC_W-1:0] func_q  [NUM_RINGS];

  logic upd_hit;
  // programming port wins over a pointer update to the same entry
  assign upd_hit = upd_we_i && !(cfg_we_i && (cfg_ring_i == upd_ring_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_RINGS; i++) begin
        base_q[i]  <= '0;
        size_q[i]  <= '0;
        pidx_q[i]  <= '0;
        color_q[i] <= 1'b0;
        vec_q[i]   <= '0;
        func_q[i]  <= '0;
      end
    end else begin
      if (cfg_we_i) begin
        base_q[cfg_ring_i]  <= cfg_base_i;
        size_q[cfg_ring_i]  <= cfg_size_i;
        pidx_q[cfg_ring_i]  <= '0;
        color_q[cfg_ring_i] <= cfg_color_i;
        vec_q[cfg_ring_i]   <= cfg_vec_i;
        func_q[cfg_ring_i]  <= cfg_func_i;
      end
      if (upd_hit) begin
        pidx_q[upd_ring_i]  <= upd_pidx_i;
        color_q[upd_ring_i] <= upd_color_i;
      end
    end
  end

  assign rd_base_o  = base_q[rd_ring_i];
  assign rd_size_o  = size_q[rd_ring_i];
  assign rd_pidx_o  = pidx_q[rd_ring_i];
  assign rd_color_o = color_q[rd_ring_i];
  assign rd_vec_o   = vec_q[rd_ring_i];
  assign rd_func_o  = func_q[rd_ring_i];
endmodule

// File: rtl/irq_ring_ptr.sv
module irq_ring_ptr #(
  parameter int ADDR_W      = 64,
  parameter int IDX_W       = 12,
  parameter int ENTRY_BYTES = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  size_i,
  input  logic [IDX_W-1:0]  pidx_i,
  input  logic              color_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IDX_W-1:0]  nxt_pidx_o,
  output logic              nxt_color_o
);
  localparam int SHIFT = $clog2(ENTRY_BYTES);

  logic [IDX_W:0] pidx_inc;
  logic           wrap;

  assign pidx_inc = {1'b0, pidx_i} + 1'b1;
  // >= keeps a corrupt index inside the ring
  assign wrap     = pidx_inc >= {1'b0, size_i};

  generate
    if (SHIFT == 0) begin : g_byte
      assign addr_o = base_i + ADDR_W'(pidx_i);
    end else begin : g_shift
      assign addr_o = base_i + (ADDR_W'(pidx_i) << SHIFT);
    end
  endgenerate

  assign nxt_pidx_o  = wrap ? '0 : pidx_inc[IDX_W-1:0];
  assign nxt_color_o = wrap ? ~color_i : color_i;
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int RING_W  = 8,
  parameter int QID_W   = 11,
  parameter int STAT_W  = 32,
  parameter int ADDR_W  = 64,
  parameter int IDX_W   = 12,
  parameter int VEC_W   = 11,
  parameter int FUNC_W  = 8,
  parameter int ENTRY_W = STAT_W + QID_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [RING_W-1:0]  req_ring_i,
  input  logic [QID_W-1:0]   req_qid_i,
  input  logic               req_c2h_i,
  input  logic [STAT_W-1:0]  req_stat_i,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  ctx_addr_i,
  input  logic               ctx_color_i,
  input  logic [VEC_W-1:0]   ctx_vec_i,
  input  logic [FUNC_W-1:0]  ctx_func_i,
  input  logic [IDX_W-1:0]   ctx_nxt_pidx_i,
  input  logic               ctx_nxt_color_i,
  output logic               upd_we_o,
  output logic [RING_W-1:0]  upd_ring_o,
  output logic [IDX_W-1:0]   upd_pidx_o,
  output logic               upd_color_o,
  output logic               mem_wr_valid_o,
  input  logic               mem_wr_ready_i,
  output logic [ADDR_W-1:0]  mem_wr_addr_o,
  output logic [ENTRY_W-1:0] mem_wr_data_o,
  input  logic               mem_cpl_i,
  output logic               msix_valid_o,
  input  logic               msix_ready_i,
  output logic [VEC_W-1:0]   msix_vec_o,
  output logic [FUNC_W-1:0]  msix_func_o
);
  agg_state_e        state_q, state_d;
  logic [ADDR_W-1:0]  addr_q;
  logic [ENTRY_W-1:0] data_q;
  logic [VEC_W-1:0]   vec_q;
  logic [FUNC_W-1:0]  func_q;
  logic               accept;

  assign req_ready_o = (state_q == ST_IDLE) && !cfg_we_i;
  assign accept      = req_valid_i && req_ready_o;

  // pointer committed at acceptance; context is never read again for this entry
  assign upd_we_o    = accept;
  assign upd_ring_o  = req_ring_i;
  assign upd_pidx_o  = ctx_nxt_pidx_i;
  assign upd_color_o = ctx_nxt_color_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (accept)         state_d = ST_WRITE;
      ST_WRITE:    if (mem_wr_ready_i) state_d = ST_WAIT_CPL;
      ST_WAIT_CPL: if (mem_cpl_i)      state_d = ST_MSIX;
      ST_MSIX:     if (msix_ready_i)   state_d = ST_IDLE;
      default:                         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      vec_q   <= '0;
      func_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= ctx_addr_i;
        data_q <= {req_stat_i, req_qid_i, req_c2h_i, ctx_color_i};
        vec_q  <= ctx_vec_i;
        func_q <= ctx_func_i;
      end
    end
  end

  assign mem_wr_valid_o = (state_q == ST_WRITE);
  assign mem_wr_addr_o  = addr_q;
  assign mem_wr_data_o  = data_q;
  assign msix_valid_o   = (state_q == ST_MSIX);
  assign msix_vec_o     = vec_q;
  assign msix_func_o    = func_q;

  // R7
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_valid_o || msix_valid_o) |-> !req_ready_o);
  // R8
  cfg_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |-> !req_ready_o);
  // R6
  msix_after_cpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msix_valid_o) |-> $past(mem_cpl_i));
  // R6
  wr_msix_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_wr_valid_o && msix_valid_o));
  // R10
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_valid_o && !mem_wr_ready_i) |=>
      (mem_wr_valid_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o)));
  // R10
  msix_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msix_valid_o && !msix_ready_i) |=>
      (msix_valid_o && $stable(msix_vec_o) && $stable(msix_func_o)));
endmodule

// File: rtl/irq_ring_writer.sv
module irq_ring_writer #(
  parameter int NUM_RINGS   = 256,
  parameter int QID_W       = 11,
  parameter int STAT_W      = 32,
  parameter int ADDR_W      = 64,
  parameter int IDX_W       = 12,
  parameter int VEC_W       = 11,
  parameter int FUNC_W      = 8,
  parameter int ENTRY_BYTES = 8,
  localparam int RING_W     = $clog2(NUM_RINGS),
  localparam int ENTRY_W    = STAT_W + QID_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [RING_W-1:0]  req_ring_i,
  input  logic [QID_W-1:0]   req_qid_i,
  input  logic               req_c2h_i,
  input  logic [STAT_W-1:0]  req_stat_i,
  input  logic               cfg_we_i,
  input  logic [RING_W-1:0]  cfg_ring_i,
  input  logic [ADDR_W-1:0]  cfg_base_i,
  input  logic [IDX_W-1:0]   cfg_size_i,
  input  logic               cfg_color_i,
  input  logic [VEC_W-1:0]   cfg_vec_i,
  input  logic [FUNC_W-1:0]  cfg_func_i,
  output logic               mem_wr_valid_o,
  input  logic               mem_wr_ready_i,
  output logic [ADDR_W-1:0]  mem_wr_addr_o,
  output logic [ENTRY_W-1:0] mem_wr_data_o,
  input  logic               mem_cpl_i,
  output logic               msix_valid_o,
  input  logic               msix_ready_i,
  output logic [VEC_W-1:0]   msix_vec_o,
  output logic [FUNC_W-1:0]  msix_func_o
);
  logic [ADDR_W-1:0] rd_base, ent_addr;
  logic [IDX_W-1:0]  rd_size, rd_pidx, nxt_pidx, upd_pidx;
  logic              rd_color, nxt_color, upd_we, upd_color;
  logic [VEC_W-1:0]  rd_vec;
  logic [FUNC_W-1:0] rd_func;
  logic [RING_W-1:0] upd_ring;

  irq_ctx_table #(
    .NUM_RINGS(NUM_RINGS), .RING_W(RING_W), .ADDR_W(ADDR_W),
    .IDX_W(IDX_W), .VEC_W(VEC_W), .FUNC_W(FUNC_W)
  ) u_ctx (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_ring_i, .cfg_base_i, .cfg_size_i,
    .cfg_color_i, .cfg_vec_i, .cfg_func_i,
    .upd_we_i(upd_we), .upd_ring_i(upd_ring),
    .upd_pidx_i(upd_pidx), .upd_color_i(upd_color),
    .rd_ring_i(req_ring_i),
    .rd_base_o(rd_base), .rd_size_o(rd_size), .rd_pidx_o(rd_pidx),
    .rd_color_o(rd_color), .rd_vec_o(rd_vec), .rd_func_o(rd_func)
  );

  irq_ring_ptr #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_ptr (
    .base_i(rd_base), .size_i(rd_size), .pidx_i(rd_pidx), .color_i(rd_color),
    .addr_o(ent_addr), .nxt_pidx_o(nxt_pidx), .nxt_color_o(nxt_color)
  );

  irq_agg_ctrl #(
    .RING_W(RING_W), .QID_W(QID_W), .STAT_W(STAT_W), .ADDR_W(ADDR_W),
    .IDX_W(IDX_W), .VEC_W(VEC_W), .FUNC_W(FUNC_W), .ENTRY_W(ENTRY_W)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_ring_i, .req_qid_i, .req_c2h_i, .req_stat_i,
    .cfg_we_i,
    .ctx_addr_i(ent_addr), .ctx_color_i(rd_color), .ctx_vec_i(rd_vec),
    .ctx_func_i(rd_func), .ctx_nxt_pidx_i(nxt_pidx), .ctx_nxt_color_i(nxt_color),
    .upd_we_o(upd_we), .upd_ring_o(upd_ring), .upd_pidx_o(upd_pidx),
    .upd_color_o(upd_color),
    .mem_wr_valid_o, .mem_wr_ready_i, .mem_wr_addr_o, .mem_wr_data_o,
    .mem_cpl_i,
    .msix_valid_o, .msix_ready_i, .msix_vec_o, .msix_func_o
  );
endmodule

// File: tb/irq_ring_writer_test.sv
module irq_ring_writer_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [7:0]  req_ring_i = '0;
  logic [10:0] req_qid_i = '0;
  logic        req_c2h_i = 1'b0;
  logic [31:0] req_stat_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_ring_i = '0;
  logic [63:0] cfg_base_i = '0;
  logic [11:0] cfg_size_i = '0;
  logic        cfg_color_i = 1'b0;
  logic [10:0] cfg_vec_i = '0;
  logic [7:0]  cfg_func_i = '0;
  logic        mem_wr_valid_o;
  logic        mem_wr_ready_i = 1'b0;
  logic [63:0] mem_wr_addr_o;
  logic [44:0] mem_wr_data_o;
  logic        mem_cpl_i = 1'b0;
  logic        msix_valid_o;
  logic        msix_ready_i = 1'b0;
  logic [10:0] msix_vec_o;
  logic [7:0]  msix_func_o;

  always #5 clk = ~clk;

  irq_ring_writer uut (
    .clk_i(clk), .rst_ni,
    .req_valid_i, .req_ready_o, .req_ring_i, .req_qid_i, .req_c2h_i, .req_stat_i,
    .cfg_we_i, .cfg_ring_i, .cfg_base_i, .cfg_size_i, .cfg_color_i, .cfg_vec_i, .cfg_func_i,
    .mem_wr_valid_o, .mem_wr_ready_i, .mem_wr_addr_o, .mem_wr_data_o, .mem_cpl_i,
    .msix_valid_o, .msix_ready_i, .msix_vec_o, .msix_func_o
  );

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference contexts
  logic [63:0] m_base  [256];
  logic [11:0] m_size  [256];
  logic [11:0] m_pidx  [256];
  logic        m_color [256];
  logic [10:0] m_vec   [256];
  logic [7:0]  m_func  [256];

  logic [63:0] exp_addr [$];
  logic [44:0] exp_data [$];
  logic [10:0] exp_vec  [$];
  logic [7:0]  exp_func [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg_drive(input int r, input logic [63:0] b, input logic [11:0] s,
                           input logic c, input logic [10:0] v, input logic [7:0] f);
    cfg_we_i = 1'b1; cfg_ring_i = 8'(r); cfg_base_i = b; cfg_size_i = s;
    cfg_color_i = c; cfg_vec_i = v; cfg_func_i = f;
    m_base[r] = b; m_size[r] = s; m_pidx[r] = '0; m_color[r] = c;
    m_vec[r] = v; m_func[r] = f;
  endtask

  task automatic cfg(input int r, input logic [63:0] b, input logic [11:0] s,
                     input logic c, input logic [10:0] v, input logic [7:0] f);
    @(negedge clk);
    cfg_drive(r, b, s, c, v, f);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic push_exp(input int r, input logic [10:0] q, input logic c2h,
                          input logic [31:0] st);
    exp_addr.push_back(m_base[r] + (64'(m_pidx[r]) << 3));
    exp_data.push_back({st, q, c2h, m_color[r]});
    exp_vec.push_back(m_vec[r]);
    exp_func.push_back(m_func[r]);
    if (m_pidx[r] + 12'd1 >= m_size[r]) begin
      m_pidx[r] = '0;
      m_color[r] = ~m_color[r];
    end else begin
      m_pidx[r] = m_pidx[r] + 12'd1;
    end
  endtask

  // called right after a falling edge
  task automatic drive_req(input int r, input logic [10:0] q, input logic c2h,
                           input logic [31:0] st);
    req_valid_i = 1'b1; req_ring_i = 8'(r); req_qid_i = q;
    req_c2h_i = c2h; req_stat_i = st;
    forever begin
      #1;
      if (req_ready_o) begin
        @(negedge clk);
        req_valid_i = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic send(input int r, input logic [10:0] q, input logic c2h,
                      input logic [31:0] st);
    @(negedge clk);
    push_exp(r, q, c2h, st);
    drive_req(r, q, c2h, st);
  endtask

  task automatic drain();
    while (exp_addr.size() != 0 || exp_vec.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // memory / message responder and scoreboard monitor
  int cyc = 0;
  int nw = 0;
  int cpl_cnt = 0;
  bit cpl_sent = 1'b0;
  bit wr_stall = 1'b0, mx_stall = 1'b0;
  logic [63:0] hold_addr;
  logic [44:0] hold_data;
  logic [10:0] hold_vec;
  logic [7:0]  hold_func;

  initial begin
    wait (rst_ni);
    forever begin
      @(negedge clk);
      cyc++;
      mem_wr_ready_i = (cyc % 3) != 0;
      msix_ready_i   = (cyc % 2) == 1;
      if (cpl_cnt == 1) begin
        mem_cpl_i = 1'b1; cpl_sent = 1'b1; cpl_cnt = 0;
      end else begin
        mem_cpl_i = 1'b0;
        if (cpl_cnt > 1) cpl_cnt--;
      end
      #1;
      if ((mem_wr_valid_o || msix_valid_o) && req_ready_o)
        chk(1'b0, "R7", "ready while busy", 64'(req_ready_o), 64'd0);
      if (mem_wr_valid_o && msix_valid_o)
        chk(1'b0, "R6", "write and message together", 64'd1, 64'd0);
      if (wr_stall) begin
        chk(mem_wr_valid_o, "R10", "write valid dropped in stall", 64'(mem_wr_valid_o), 64'd1);
        chk(mem_wr_addr_o == hold_addr && mem_wr_data_o == hold_data, "R10",
            "write held", mem_wr_addr_o, hold_addr);
      end
      if (mx_stall) begin
        chk(msix_valid_o && msix_vec_o == hold_vec && msix_func_o == hold_func, "R10",
            "message held", 64'(msix_vec_o), 64'(hold_vec));
      end
      wr_stall = mem_wr_valid_o && !mem_wr_ready_i;
      mx_stall = msix_valid_o && !msix_ready_i;
      hold_addr = mem_wr_addr_o; hold_data = mem_wr_data_o;
      hold_vec = msix_vec_o; hold_func = msix_func_o;
      if (mem_wr_valid_o && mem_wr_ready_i) begin
        if (exp_addr.size() == 0) begin
          chk(1'b0, "R2", "unexpected write", mem_wr_addr_o, 64'd0);
        end else begin
          logic [63:0] ea;
          logic [44:0] ed;
          ea = exp_addr.pop_front();
          ed = exp_data.pop_front();
          // R2 R4 R9 address from per-ring index
          chk(mem_wr_addr_o == ea, "R2/R4/R9", "entry address", mem_wr_addr_o, ea);
          // R3 layout, R5 color
          chk(mem_wr_data_o[44:1] == ed[44:1], "R3", "entry payload", 64'(mem_wr_data_o), 64'(ed));
          chk(mem_wr_data_o[0] == ed[0], "R5", "entry color", 64'(mem_wr_data_o[0]), 64'(ed[0]));
        end
        cpl_cnt = 2 + (nw % 3);
        cpl_sent = 1'b0;
        nw++;
      end
      if (msix_valid_o && msix_ready_i) begin
        chk(cpl_sent, "R6", "message before completion", 64'(cpl_sent), 64'd1);
        if (exp_vec.size() == 0) begin
          chk(1'b0, "R6", "unexpected message", 64'(msix_vec_o), 64'd0);
        end else begin
          logic [10:0] ev;
          logic [7:0]  ef;
          ev = exp_vec.pop_front();
          ef = exp_func.pop_front();
          chk(msix_vec_o == ev && msix_func_o == ef, "R6", "vector/function",
              {45'd0, msix_func_o, msix_vec_o}, {45'd0, ef, ev});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      m_base[i] = '0; m_size[i] = '0; m_pidx[i] = '0;
      m_color[i] = 1'b0; m_vec[i] = '0; m_func[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(req_ready_o == 1'b1, "R1", "ready in reset", 64'(req_ready_o), 64'd1);
    chk(mem_wr_valid_o == 1'b0, "R1", "write valid in reset", 64'(mem_wr_valid_o), 64'd0);
    chk(msix_valid_o == 1'b0, "R1", "message valid in reset", 64'(msix_valid_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o && !mem_wr_valid_o && !msix_valid_o, "R1", "idle after reset",
        {61'd0, req_ready_o, mem_wr_valid_o, msix_valid_o}, 64'd4);

    cfg(3,   64'h0000_0000_1000_0000, 12'd4, 1'b1, 11'd7,    8'd2);
    cfg(200, 64'h0000_0002_0000_0400, 12'd5, 1'b1, 11'd300,  8'd9);
    cfg(255, 64'h0000_0000_FFFF_0000, 12'd2, 1'b1, 11'd2047, 8'd255);

    // long run with wraps, interleaved rings (R4 R5 R9)
    for (int i = 0; i < 9; i++) begin
      send(3, 11'(i), i[0], 32'hA500_0000 + i);
      if (i % 3 == 0) send(200, 11'(100 + i), 1'b1, 32'h5A00_0000 + i);
      if (i % 2 == 0) send(255, 11'(2000 + i), 1'b0, 32'hC3C3_0000 + i);
    end
    drain();

    // R8: programming and request in the same cycle
    @(negedge clk);
    cfg_drive(3, 64'h0000_0000_3000_0000, 12'd3, 1'b1, 11'd55, 8'd4);
    req_valid_i = 1'b1; req_ring_i = 8'd3; req_qid_i = 11'd77;
    req_c2h_i = 1'b1; req_stat_i = 32'hDEAD_BEEF;
    #1;
    chk(req_ready_o == 1'b0, "R8", "ready during programming", 64'(req_ready_o), 64'd0);
    @(negedge clk);
    cfg_we_i = 1'b0;
    push_exp(3, 11'd77, 1'b1, 32'hDEAD_BEEF);
    drive_req(3, 11'd77, 1'b1, 32'hDEAD_BEEF);
    drain();

    // R5: reprogram with color 0, wrap to 1
    cfg(200, 64'h0000_0002_0000_8000, 12'd3, 1'b0, 11'd12, 8'd1);
    for (int i = 0; i < 4; i++) send(200, 11'(i + 5), 1'b0, 32'h0101_0000 + i);
    send(3, 11'd9, 1'b0, 32'h0000_0009);
    drain();

    chk(exp_addr.size() == 0 && exp_vec.size() == 0, "R2", "all items seen",
        64'(exp_addr.size()), 64'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule